// File: doc/BRIEF.md
# Direct-Mapped Data Cache Tag Array Controller

This block holds the tag and data storage of a direct-mapped data cache with 32-byte lines. Software reaches both arrays through a memory-mapped direct-access port. A tag access reads or replaces the entry of one line. A data access reads or writes one 32-bit word of the data array. A separate command clears the valid and dirty state of every line.

Replacing a tag that still describes modified data must not lose that data. When a direct tag write lands on a line that is both valid and dirty, the block first pushes the old 32 bytes to external memory through a single-beat burst request with an acknowledge. It installs the new tag only once that push has been acknowledged. While the burst or the clearing sweep is in progress the access port stalls. The hit and miss handling of the pipeline and lookups through address translation are outside this block.

Top module: `dcache_tagctl`

## Requirements
- R1: After reset every line is invalid and clean: tag reads return 0 in bits 1:0, `req_ready` is 1, and `busy`, `wb_req` and `rsp_valid` are 0.
- R2: A tag write (`req_write`=1, `req_data`=0) with address bit 3 at 0 stores the written value masked with 0x1FFFFC03 into the line chosen by address bits 13:5. A tag read returns that stored value, with physical address bits 28:10, dirty in bit 1 and valid in bit 0. `rsp_valid` and `rsp_rdata` appear on the clock edge after the edge that accepts the read.
- R3: A tag write with address bit 3 at 1 changes no state and starts no writeback.
- R4: A data access (`req_data`=1) selects one 32-bit word by address bits 13:2. Writes store the word, and reads return it on the edge after acceptance.
- R5: A tag write with bit 3 at 0 to a line whose valid and dirty flags are both set raises `wb_req` from the edge that accepts it. `wb_addr` is then {old tag bits 28:10, address bits 9:5, five zero bits}. `wb_data` carries the line's 8 words, with the word at byte offset 0 in bits 31:0 and higher offsets above it.
- R6: While `wb_req` is high, `req_ready` is 0, `busy` is 1, and `wb_req` and `wb_addr` hold until `wb_ack`. The new tag is installed on the edge that samples `wb_ack`, and `wb_req` is low after that edge.
- R7: A tag write to a line that is not both valid and dirty installs the tag on its accepting edge and leaves `wb_req` low.
- R8: An `inv_req` pulse accepted while idle holds `busy` high for exactly 512 cycles, one per line. Afterwards every line reads with bits 1:0 at 0 and its address bits kept.
- R9: `inv_req` takes priority over a request in the same cycle (`req_ready` is 0). A request that is pending during the sweep is accepted on the first edge after `busy` falls.
- R10: An `inv_req` seen during a writeback is remembered. When the acknowledge arrives, the new tag is installed and the 512-cycle sweep follows at once, with `busy` staying high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Direct-access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data | input | 1 | 1 = data array, 0 = tag array |
| req_addr | input | 12 (bits 13:2) | Access address word bits |
| req_wdata | input | 32 | Write value |
| req_ready | output | 1 | Request accepted on this edge when high |
| rsp_valid | output | 1 | Read result valid |
| rsp_rdata | output | 32 | Read result |
| inv_req | input | 1 | Global invalidate command pulse |
| busy | output | 1 | Writeback or sweep in progress |
| wb_req | output | 1 | Writeback burst request |
| wb_addr | output | 32 | Writeback line address |
| wb_data | output | 256 | Writeback line contents |
| wb_ack | input | 1 | External memory accepted the burst |

## Verification
Read results are due one edge after acceptance, so the bench drives each request on a falling edge and releases it on the falling edge that follows the accepting rising edge. It samples `rsp_rdata` at that point. `wb_req` and its address and data are due on the edge that accepts the tag write, and the bench reads them on the next falling edge. It holds the acknowledge off for several cycles to confirm that they stay put. For the sweep, the bench counts the falling edges on which `busy` is high, expecting exactly 512. It also counts how long a request stalls behind the sweep, expecting 512 waiting edges before acceptance.

// File: rtl/dctag_pkg.sv
package dctag_pkg;

    localparam int WORD_W     = 32;
    localparam int LINE_BYTES = 32;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int WPL        = LINE_BYTES / 4;
    localparam int WSEL_W     = $clog2(WPL);
    localparam int LINE_BITS  = LINE_BYTES * 8;
    localparam int PA_LSB     = 10;
    localparam int PA_MSB     = 28;
    localparam int PA_W       = PA_MSB - PA_LSB + 1;
    localparam int ASSOC_BIT  = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SWEEP,
        SEQ_WB
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_TAG_WR,
        OP_TAG_RD,
        OP_DATA_WR,
        OP_DATA_RD
    } acc_op_e;

    typedef struct packed {
        logic [PA_W-1:0] pa;
        logic            dirty;
        logic            valid;
    } tag_ent_t;

    function automatic acc_op_e decode_op(input logic is_write, input logic is_data);
        case ({is_data, is_write})
            2'b01:   return OP_TAG_WR;
            2'b00:   return OP_TAG_RD;
            2'b11:   return OP_DATA_WR;
            default: return OP_DATA_RD;
        endcase
    endfunction

    function automatic tag_ent_t tag_from_word(input logic [WORD_W-1:0] w);
        tag_ent_t t;
        t.pa    = w[PA_MSB:PA_LSB];
        t.dirty = w[1];
        t.valid = w[0];
        return t;
    endfunction

    function automatic logic [WORD_W-1:0] tag_to_word(input tag_ent_t t);
        logic [WORD_W-1:0] w;
        w = '0;
        w[PA_MSB:PA_LSB] = t.pa;
        w[1] = t.dirty;
        w[0] = t.valid;
        return w;
    endfunction

endpackage

// File: rtl/dctag_flags.sv
module dctag_flags
    import dctag_pkg::*;
#(
    parameter int LINES = 512,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             set_valid,
    input  logic             set_dirty,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty
);

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (clr_en) begin
                valid_q[clr_idx] <= 1'b0;
                dirty_q[clr_idx] <= 1'b0;
            end
            if (set_en) begin
                valid_q[set_idx] <= set_valid;
                dirty_q[set_idx] <= set_dirty;
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];

    // R8: a swept line is left invalid and clean
    assert_sweep_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en) |=> (!valid_q[$past(clr_idx)] && !dirty_q[$past(clr_idx)]));

    // R2: an installed tag carries the written flags
    assert_flags_installed_R2: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clr_en) |=> (valid_q[$past(set_idx)] == $past(set_valid)
                                 && dirty_q[$past(set_idx)] == $past(set_dirty)));

endmodule

// File: rtl/dctag_store.sv
module dctag_store
    import dctag_pkg::*;
#(
    parameter int LINES = 512,
    localparam int IDX_W = $clog2(LINES),
    localparam int WIDX_W = IDX_W + WSEL_W
) (
    input  logic                  clk,
    input  logic                  tag_we,
    input  logic [IDX_W-1:0]      tag_widx,
    input  logic [PA_W-1:0]       tag_wpa,
    input  logic [IDX_W-1:0]      tag_ridx,
    output logic [PA_W-1:0]       tag_rpa,
    input  logic                  data_we,
    input  logic [WIDX_W-1:0]     data_widx,
    input  logic [WORD_W-1:0]     data_wword,
    input  logic [WIDX_W-1:0]     data_ridx,
    output logic [WORD_W-1:0]     data_rword,
    input  logic [IDX_W-1:0]      line_idx,
    output logic [LINE_BITS-1:0]  line_bits
);

    logic [PA_W-1:0]   pa_mem  [LINES];
    logic [WORD_W-1:0] dat_mem [LINES*WPL];

    always_ff @(posedge clk) begin
        if (tag_we)  pa_mem[tag_widx]   <= tag_wpa;
        if (data_we) dat_mem[data_widx] <= data_wword;
    end

    assign tag_rpa    = pa_mem[tag_ridx];
    assign data_rword = dat_mem[data_ridx];

    for (genvar w = 0; w < WPL; w++) begin : g_line_word
        assign line_bits[w*WORD_W +: WORD_W] = dat_mem[{line_idx, WSEL_W'(w)}];
    end

endmodule

// File: rtl/dctag_seq.sv
module dctag_seq
    import dctag_pkg::*;
#(
    parameter int LINES = 512,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  acc_op_e          req_op,
    input  logic             req_assoc,
    input  logic [IDX_W-1:0] req_idx,
    input  tag_ent_t         req_tag,
    input  logic             old_valid,
    input  logic             old_dirty,
    input  logic             inv_req,
    input  logic             wb_ack,
    output logic             req_ready,
    output logic             accept,
    output logic             busy,
    output logic             wb_req,
    output logic [IDX_W-1:0] look_idx,
    output logic             commit_en,
    output logic [IDX_W-1:0] commit_idx,
    output tag_ent_t         commit_tag,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx
);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] sweep_q;
    logic [IDX_W-1:0] pend_idx_q;
    tag_ent_t         pend_tag_q;
    logic             inv_pend_q;
    logic             tw_direct;
    logic             need_wb;
    logic             sweep_last;

    assign req_ready  = (state_q == SEQ_IDLE) && !inv_req && !inv_pend_q;
    assign accept     = req_valid && req_ready;
    assign busy       = (state_q != SEQ_IDLE);
    assign wb_req     = (state_q == SEQ_WB);
    assign tw_direct  = accept && (req_op == OP_TAG_WR) && !req_assoc;
    assign need_wb    = tw_direct && old_valid && old_dirty;
    assign look_idx   = (state_q == SEQ_WB) ? pend_idx_q : req_idx;
    assign sweep_last = (sweep_q == IDX_W'(LINES - 1));
    assign clr_en     = (state_q == SEQ_SWEEP);
    assign clr_idx    = sweep_q;

    always_comb begin
        commit_en  = 1'b0;
        commit_idx = req_idx;
        commit_tag = req_tag;
        if (state_q == SEQ_WB) begin
            commit_en  = wb_ack;
            commit_idx = pend_idx_q;
            commit_tag = pend_tag_q;
        end else if (tw_direct && !need_wb) begin
            commit_en = 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_IDLE: begin
                if (inv_req || inv_pend_q) state_d = SEQ_SWEEP;
                else if (need_wb)          state_d = SEQ_WB;
            end
            SEQ_SWEEP: begin
                if (sweep_last) state_d = SEQ_IDLE;
            end
            SEQ_WB: begin
                if (wb_ack) state_d = (inv_pend_q || inv_req) ? SEQ_SWEEP : SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SEQ_IDLE;
            sweep_q    <= '0;
            pend_idx_q <= '0;
            pend_tag_q <= '0;
            inv_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == SEQ_SWEEP) sweep_q <= sweep_q + 1'b1;
            else                      sweep_q <= '0;
            if (need_wb) begin
                pend_idx_q <= req_idx;
                pend_tag_q <= req_tag;
            end
            if (state_d == SEQ_SWEEP)                     inv_pend_q <= 1'b0;
            else if (state_q == SEQ_WB && inv_req)        inv_pend_q <= 1'b1;
        end
    end

    // R6: the port stays closed while a burst or sweep runs
    assert_stall_when_busy_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ready);

    // R6: the burst request and its line hold until acknowledged
    assert_wb_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (wb_req && !wb_ack) |=> (wb_req && $stable(pend_idx_q)));

    // R3: an associative tag write installs nothing and starts no burst
    assert_assoc_noop_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && req_op == OP_TAG_WR && req_assoc) |-> (!commit_en ##1 !wb_req));

    // R8: the sweep ends after its last line
    assert_sweep_ends_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_en && sweep_last) |=> !clr_en);

    // R10: an invalidate seen during a burst runs right after the acknowledge
    assert_wb_then_sweep_R10: assert property (@(posedge clk) disable iff (rst)
        (wb_req && wb_ack && inv_pend_q) |=> clr_en);

    // R9: invalidate wins over a same-cycle request
    assert_inv_priority_R9: assert property (@(posedge clk) disable iff (rst)
        inv_req |-> !req_ready);

endmodule

// File: rtl/dcache_tagctl.sv
module dcache_tagctl
    import dctag_pkg::*;
#(
    parameter int LINES = 512,
    localparam int IDX_W  = $clog2(LINES),
    localparam int ADDR_W = IDX_W + OFF_W,
    localparam int WIDX_W = IDX_W + WSEL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_data,
    input  logic [ADDR_W-1:2]    req_addr,
    input  logic [WORD_W-1:0]    req_wdata,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic [WORD_W-1:0]    rsp_rdata,
    input  logic                 inv_req,
    output logic                 busy,
    output logic                 wb_req,
    output logic [WORD_W-1:0]    wb_addr,
    output logic [LINE_BITS-1:0] wb_data,
    input  logic                 wb_ack
);

    localparam int LOW_IDX_W = PA_LSB - OFF_W;

    acc_op_e          op;
    logic             accept;
    logic [IDX_W-1:0] req_idx;
    logic [IDX_W-1:0] look_idx;
    logic             old_valid, old_dirty;
    logic             commit_en;
    logic [IDX_W-1:0] commit_idx;
    tag_ent_t         commit_tag;
    logic             clr_en;
    logic [IDX_W-1:0] clr_idx;
    logic [PA_W-1:0]  look_pa;
    logic [WORD_W-1:0] data_rword;
    logic [WIDX_W-1:0] word_idx;
    tag_ent_t         look_tag;

    assign op       = decode_op(req_write, req_data);
    assign req_idx  = req_addr[ADDR_W-1:OFF_W];
    assign word_idx = req_addr[ADDR_W-1:2];

    dctag_seq #(.LINES(LINES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_op     (op),
        .req_assoc  (req_addr[ASSOC_BIT]),
        .req_idx    (req_idx),
        .req_tag    (tag_from_word(req_wdata)),
        .old_valid  (old_valid),
        .old_dirty  (old_dirty),
        .inv_req    (inv_req),
        .wb_ack     (wb_ack),
        .req_ready  (req_ready),
        .accept     (accept),
        .busy       (busy),
        .wb_req     (wb_req),
        .look_idx   (look_idx),
        .commit_en  (commit_en),
        .commit_idx (commit_idx),
        .commit_tag (commit_tag),
        .clr_en     (clr_en),
        .clr_idx    (clr_idx)
    );

    dctag_flags #(.LINES(LINES)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx),
        .set_en    (commit_en),
        .set_idx   (commit_idx),
        .set_valid (commit_tag.valid),
        .set_dirty (commit_tag.dirty),
        .rd_idx    (look_idx),
        .rd_valid  (old_valid),
        .rd_dirty  (old_dirty)
    );

    dctag_store #(.LINES(LINES)) u_store (
        .clk        (clk),
        .tag_we     (commit_en),
        .tag_widx   (commit_idx),
        .tag_wpa    (commit_tag.pa),
        .tag_ridx   (look_idx),
        .tag_rpa    (look_pa),
        .data_we    (accept && op == OP_DATA_WR),
        .data_widx  (word_idx),
        .data_wword (req_wdata),
        .data_ridx  (word_idx),
        .data_rword (data_rword),
        .line_idx   (look_idx),
        .line_bits  (wb_data)
    );

    assign look_tag = '{pa: look_pa, dirty: old_dirty, valid: old_valid};
    assign wb_addr  = {{(WORD_W-PA_MSB-1){1'b0}}, look_pa, look_idx[LOW_IDX_W-1:0], {OFF_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= accept && (op == OP_TAG_RD || op == OP_DATA_RD);
            if (accept && op == OP_TAG_RD)       rsp_rdata <= tag_to_word(look_tag);
            else if (accept && op == OP_DATA_RD) rsp_rdata <= data_rword;
        end
    end

    // R4: every accepted read answers on the next edge
    assert_read_resp_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_write) |=> rsp_valid);

    // R6: the burst target stays fixed until acknowledged
    assert_wb_addr_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (wb_req && !wb_ack) |=> $stable(wb_addr));

    // R5: a burst only ever pushes a valid, dirty line
    assert_wb_line_dirty_R5: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> (old_valid && old_dirty));

endmodule

// File: tb/sim_dcache_tagctl.sv
module sim_dcache_tagctl;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid, req_write, req_data;
    logic [13:0]  a14;
    logic [31:0]  req_wdata;
    logic         req_ready, rsp_valid;
    logic [31:0]  rsp_rdata;
    logic         inv_req, busy, wb_req, wb_ack;
    logic [31:0]  wb_addr;
    logic [255:0] wb_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dcache_tagctl u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_data(req_data),
        .req_addr(a14[13:2]), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .inv_req(inv_req), .busy(busy),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data), .wb_ack(wb_ack)
    );

    // op: 0 tag write, 1 tag read, 2 data write, 3 data read
    // fields: {op[1:0], addr[13:0], wdata[31:0], expected[31:0]}
    localparam int NV = 14;
    localparam logic [79:0] VEC [NV] = '{
        {2'd0, 14'h0060, 32'hA5A5A5A5, 32'h00000000},
        {2'd1, 14'h0060, 32'h00000000, 32'h05A5A401},
        {2'd0, 14'h1900, 32'hFFFFFFFE, 32'h00000000},
        {2'd1, 14'h1900, 32'h00000000, 32'h1FFFFC02},
        {2'd0, 14'h0068, 32'h00000000, 32'h00000000},
        {2'd1, 14'h0060, 32'h00000000, 32'h05A5A401},
        {2'd2, 14'h0004, 32'h11223344, 32'h00000000},
        {2'd2, 14'h3FFC, 32'hCAFEF00D, 32'h00000000},
        {2'd3, 14'h0004, 32'h00000000, 32'h11223344},
        {2'd3, 14'h3FFC, 32'h00000000, 32'hCAFEF00D},
        {2'd0, 14'h0060, 32'h00000000, 32'h00000000},
        {2'd1, 14'h0060, 32'h00000000, 32'h00000000},
        {2'd0, 14'h1900, 32'h12345679, 32'h00000000},
        {2'd1, 14'h1900, 32'h00000000, 32'h12345401}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [1:0] op, input logic [13:0] a, input logic [31:0] d,
                        output logic [31:0] q, output int waits);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = ~op[0];
        req_data  = op[1];
        a14       = a;
        req_wdata = d;
        waits     = 0;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            waits++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        q = rsp_rdata;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] q;
        int w, n;
        rst = 1'b1; req_valid = 0; req_write = 0; req_data = 0; a14 = '0;
        req_wdata = '0; inv_req = 0; wb_ack = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 ready", {31'd0, req_ready}, 32'd1);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 wb_req", {31'd0, wb_req}, 32'd0);
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        xfer(2'd1, 14'h00E0, 32'd0, q, w);
        chk("R1 flags", {30'd0, q[1:0]}, 32'd0);

        // vector table: R2, R3, R4, R7
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            op = VEC[i][79:78];
            xfer(op, VEC[i][77:64], VEC[i][63:32], q, w);
            if (op == 2'd0) chk("R7 no burst", {31'd0, wb_req}, 32'd0);
            else if (op == 2'd1) chk("R2 tag read", q, VEC[i][31:0]);
            else if (op == 2'd3) chk("R4 data read", q, VEC[i][31:0]);
        end

        // R3 associative write ignored
        xfer(2'd0, 14'h1908, 32'hFFFFFFFF, q, w);
        chk("R3 no burst", {31'd0, wb_req}, 32'd0);
        xfer(2'd1, 14'h1900, 32'd0, q, w);
        chk("R3 tag kept", q, 32'h12345401);

        // R5 / R6 writeback of a dirty line (index 37)
        xfer(2'd0, 14'h04A0, 32'h0ABCD403, q, w);
        chk("R7 clean old line", {31'd0, wb_req}, 32'd0);
        for (int k = 0; k < 8; k++)
            xfer(2'd2, 14'h04A0 + 14'(k*4), 32'hD0000000 + k, q, w);
        xfer(2'd0, 14'h04A0, 32'h00000401, q, w);
        chk("R5 wb_req", {31'd0, wb_req}, 32'd1);
        chk("R5 wb_addr", wb_addr, 32'h0ABCD4A0);
        for (int k = 0; k < 8; k++)
            chk("R5 wb_data", wb_data[k*32 +: 32], 32'hD0000000 + k);
        repeat (3) @(negedge clk);
        chk("R6 wb held", {31'd0, wb_req}, 32'd1);
        chk("R6 addr held", wb_addr, 32'h0ABCD4A0);
        chk("R6 ready low", {31'd0, req_ready}, 32'd0);
        chk("R6 busy", {31'd0, busy}, 32'd1);
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
        chk("R6 wb done", {31'd0, wb_req}, 32'd0);
        chk("R6 ready back", {31'd0, req_ready}, 32'd1);
        xfer(2'd1, 14'h04A0, 32'd0, q, w);
        chk("R6 new tag", q, 32'h00000401);

        // R10 invalidate during writeback
        xfer(2'd0, 14'h04A0, 32'h00000403, q, w);
        chk("R7 valid-only old", {31'd0, wb_req}, 32'd0);
        xfer(2'd0, 14'h04A0, 32'h00000800, q, w);
        chk("R10 burst", wb_addr, 32'h000004A0);
        inv_req = 1'b1;
        @(negedge clk);
        inv_req = 1'b0;
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
        count_busy(n);
        chk("R10 sweep follows", n, 32'd512);
        xfer(2'd1, 14'h04A0, 32'd0, q, w);
        chk("R10 tag swept", q, 32'h00000800);

        // R8 invalidate sweep
        xfer(2'd0, 14'h0060, 32'h00001C01, q, w);
        xfer(2'd0, 14'h3FE0, 32'hFFFFFFFF, q, w);
        chk("R7 fresh line", {31'd0, wb_req}, 32'd0);
        @(negedge clk);
        inv_req = 1'b1;
        @(negedge clk);
        inv_req = 1'b0;
        count_busy(n);
        chk("R8 sweep length", n, 32'd512);
        xfer(2'd1, 14'h0060, 32'd0, q, w);
        chk("R8 line 3", q, 32'h00001C00);
        xfer(2'd1, 14'h3FE0, 32'd0, q, w);
        chk("R8 last line", q, 32'h1FFFFC00);
        xfer(2'd0, 14'h3FE0, 32'h00000001, q, w);
        chk("R8 no stale burst", {31'd0, wb_req}, 32'd0);

        // R9 same-cycle priority and stall behind the sweep
        @(negedge clk);
        inv_req = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_data = 1'b0;
        a14 = 14'h3FE0;
        #1;
        chk("R9 inv wins", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        inv_req = 1'b0;
        w = 0;
        while (!req_ready) begin
            w++;
            @(negedge clk);
        end
        chk("R9 stall length", w, 32'd512);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 resp valid", {31'd0, rsp_valid}, 32'd1);
        chk("R9 read after sweep", rsp_rdata, 32'h00000000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule